// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses one interrupt among a set of request lines and presents it to a CPU. Software gives each line a 3-bit priority level. The controller keeps a running priority level and a global mask bit. When the CPU accepts an interrupt, the controller saves the current level and mask on an internal stack, then raises the running level to that of the accepted source and sets the mask. A return strobe restores the saved context. A mask-clear strobe lets a handler open itself to sources of strictly higher level, and this is how nesting happens.

Levels are written through a small window. An 8-bit base register keeps only the upper nibble of a vector address. Eight window entries then select the sources that lie in that 16-byte block. Each vector occupies two bytes, so source `s` has vector address `2*s`. Window entry `e` under base `b` reaches source `{b[7:4], e}`.

Top module: `prio_intc`

## Requirements
- R1: After reset, every source level reads back as 1, the base register reads 0x00, the mask bit is set, the running level is 0 and `irq_o` is low whatever the requests are.
- R2: A source whose level is 0 never raises `irq_o` and never appears on `vec_o` while `irq_o` is high.
- R3: Among requesting sources with a nonzero level, the highest level wins. When several sources share that level, the one with the larger index (the higher vector address) wins.
- R4: With the mask clear, `irq_o` is high only if the winner's level is strictly greater than the running level. A source equal to the running level cannot nest.
- R5: A cycle with `ack_i` high while `irq_o` is high accepts the winner. From the next cycle the mask is set and the running level equals the accepted level. `ack_i` while `irq_o` is low has no effect.
- R6: While the mask bit is set, `irq_o` stays low. A `cli_i` pulse clears the mask from the next cycle.
- R7: An `rti_i` pulse pops the newest saved (level, mask) pair and restores both. `rti_i` with an empty stack changes nothing. An acceptance in the same cycle takes precedence over `rti_i` and `cli_i`.
- R8: A write with `cfg_win_i=0` stores `cfg_wdata_i & 0xF0` in the base register. A write with `cfg_win_i=1` stores `cfg_wdata_i[2:0]` as the level of source `{base[7:4], cfg_ent_i}`. Reads on `cfg_rdata_o` return the same fields combinationally. A window entry that maps past the last source reads 0, and writes to it are ignored.
- R9: While `irq_o` is high, `vec_o` is the winner's index. After an acceptance, `vec_o` holds the accepted index until the next acceptance, whatever happens to the requests.
- R10: The context stack holds at least one entry for each possible nesting step, so an acceptance never finds it full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Level-sensitive interrupt request lines |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| rti_i | input | 1 | Return-from-interrupt strobe |
| cli_i | input | 1 | Clear the global mask bit |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_win_i | input | 1 | 0 selects the base register, 1 selects the window |
| cfg_ent_i | input | 3 | Window entry select |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for the current selection |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | $clog2(NUM_SRC) | Index of the presented or accepted source |

## Verification
The bench puts two requests of the same level in competition and expects the larger index. A design with a reversed tie-break scan would present the smaller one. A pending source equal to the running level is held high after the mask is cleared. A comparison that uses greater-or-equal would re-enter the same handler forever. The bench nests three levels deep and then unwinds with returns, checking at each step which pending source comes back. A broken stack would restore the wrong level and either present a stale request or hide a valid one. The bench also checks that sources set to level 0, out-of-range window entries and stray acknowledges or returns leave no trace.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned PRIO_W = 3;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned WIN_N  = 8;
    localparam int unsigned ENT_W  = $clog2(WIN_N);
    localparam int unsigned BASE_W = ADDR_W - ENT_W - 1;

    typedef logic [PRIO_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t lvl;
        logic mask;
    } ctx_t;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_i,
    input  logic                          win_i,
    input  logic [ENT_W-1:0]              ent_i,
    input  logic [ADDR_W-1:0]             wdata_i,
    output logic [ADDR_W-1:0]             rdata_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_o
);
    localparam int unsigned SEL_W = BASE_W + ENT_W;
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [BASE_W-1:0]               base;
        logic [NUM_SRC-1:0][PRIO_W-1:0]  lvl;
    } cfg_st_t;

    cfg_st_t          st_d, st_q;
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] idx;
    logic             hit;

    always_comb begin
        sel  = {st_q.base, ent_i};
        idx  = sel[IDX_W-1:0];
        hit  = (32'(sel) < NUM_SRC);
        st_d = st_q;
        if (wr_i && !win_i) begin
            st_d.base = wdata_i[ADDR_W-1:ENT_W+1];
        end
        if (wr_i && win_i && hit) begin
            st_d.lvl[idx] = wdata_i[PRIO_W-1:0];
        end
        if (win_i) begin
            rdata_o = hit ? ADDR_W'(st_q.lvl[idx]) : '0;
        end else begin
            rdata_o = {st_q.base, {(ENT_W+1){1'b0}}};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.base <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                st_q.lvl[i] <= PRIO_W'(1);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    // R8
    base_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && win_i) |=> $stable(st_q.base));
endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_i,
    input  lvl_t                           run_lvl_i,
    input  logic                           mask_i,
    output logic                           irq_o,
    output logic [$clog2(NUM_SRC)-1:0]     win_idx_o,
    output lvl_t                           win_lvl_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    always_comb begin
        win_lvl_o = '0;
        win_idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (lvl_i[i] != '0) && (lvl_i[i] >= win_lvl_o)) begin
                win_lvl_o = lvl_i[i];
                win_idx_o = IDX_W'(i);
            end
        end
        irq_o = !mask_i && (win_lvl_o > run_lvl_i);
    end
endmodule

// File: rtl/pic_ctx.sv
module pic_ctx
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned STK_D   = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       fire_i,
    input  logic [$clog2(NUM_SRC)-1:0] win_idx_i,
    input  lvl_t                       win_lvl_i,
    input  logic                       rti_i,
    input  logic                       cli_i,
    output lvl_t                       run_lvl_o,
    output logic                       mask_o,
    output logic [$clog2(NUM_SRC)-1:0] act_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);
    localparam int unsigned SP_W  = $clog2(STK_D + 1);
    localparam int unsigned STK_W = (STK_D > 1) ? $clog2(STK_D) : 1;

    typedef struct packed {
        lvl_t                  lvl;
        logic                  mask;
        logic [IDX_W-1:0]      act;
        logic [SP_W-1:0]       sp;
        ctx_t [STK_D-1:0]      stk;
    } ctx_st_t;

    ctx_st_t         st_d, st_q;
    logic [SP_W-1:0] top;

    always_comb begin
        st_d = st_q;
        top  = st_q.sp - 1'b1;
        if (cli_i) begin
            st_d.mask = 1'b0;
        end
        if (rti_i && (st_q.sp != '0)) begin
            st_d.lvl  = st_q.stk[top[STK_W-1:0]].lvl;
            st_d.mask = st_q.stk[top[STK_W-1:0]].mask;
            st_d.sp   = top;
        end
        if (fire_i && (32'(st_q.sp) < STK_D)) begin
            st_d      = st_q;
            st_d.stk[st_q.sp[STK_W-1:0]] = '{lvl: st_q.lvl, mask: st_q.mask};
            st_d.sp   = st_q.sp + 1'b1;
            st_d.lvl  = win_lvl_i;
            st_d.mask = 1'b1;
            st_d.act  = win_idx_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_lvl_o = st_q.lvl;
    assign mask_o    = st_q.mask;
    assign act_o     = st_q.act;

    // R10
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |-> (32'(st_q.sp) < STK_D));
    // R5
    entry_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> (st_q.mask && (st_q.lvl == $past(win_lvl_i))));
    // R7
    empty_rti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rti_i && !fire_i && !cli_i && (st_q.sp == '0)) |=> ($stable(st_q.lvl) && $stable(st_q.mask)));
    // R6
    cli_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cli_i && !fire_i && !rti_i) |=> !st_q.mask);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned STK_D   = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_SRC-1:0]         req_i,
    input  logic                       ack_i,
    input  logic                       rti_i,
    input  logic                       cli_i,
    input  logic                       cfg_wr_i,
    input  logic                       cfg_win_i,
    input  logic [ENT_W-1:0]           cfg_ent_i,
    input  logic [ADDR_W-1:0]          cfg_wdata_i,
    output logic [ADDR_W-1:0]          cfg_rdata_o,
    output logic                       irq_o,
    output logic [$clog2(NUM_SRC)-1:0] vec_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0][PRIO_W-1:0] lvls;
    lvl_t                           run_lvl, win_lvl;
    logic                           mask, irq, fire;
    logic [IDX_W-1:0]               win_idx, act_idx;

    pic_cfg #(.NUM_SRC(NUM_SRC)) i_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .win_i   (cfg_win_i),
        .ent_i   (cfg_ent_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .lvl_o   (lvls)
    );

    pic_arb #(.NUM_SRC(NUM_SRC)) i_arb (
        .req_i     (req_i),
        .lvl_i     (lvls),
        .run_lvl_i (run_lvl),
        .mask_i    (mask),
        .irq_o     (irq),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    assign fire = ack_i && irq;

    pic_ctx #(.NUM_SRC(NUM_SRC), .STK_D(STK_D)) i_ctx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (fire),
        .win_idx_i (win_idx),
        .win_lvl_i (win_lvl),
        .rti_i     (rti_i),
        .cli_i     (cli_i),
        .run_lvl_o (run_lvl),
        .mask_o    (mask),
        .act_o     (act_idx)
    );

    assign irq_o = irq;
    assign vec_o = irq ? win_idx : act_idx;

    // R6
    mask_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask |-> !irq_o);
    // R4
    strict_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (win_lvl > run_lvl));
    // R2
    lvl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (lvls[vec_o] != '0));
    // R9
    vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> (vec_o == $past(vec_o)));
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        ack = 1'b0, rti = 1'b0, cli = 1'b0;
    logic        cfg_wr = 1'b0, cfg_win = 1'b0;
    logic [2:0]  cfg_ent = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        irq;
    logic [3:0]  vec;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    prio_intc i_prio_intc (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack), .rti_i(rti),
        .cli_i(cli), .cfg_wr_i(cfg_wr), .cfg_win_i(cfg_win), .cfg_ent_i(cfg_ent),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .irq_o(irq), .vec_o(vec)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic win, logic [2:0] ent, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_win = win; cfg_ent = ent; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic win, logic [2:0] ent, output int d);
        cfg_win = win; cfg_ent = ent;
        #1 d = int'(cfg_rdata);
    endtask

    task automatic set_lvl(int src, int l);
        bus_wr(1'b0, 3'd0, 8'((src * 2) & 8'hF0));
        bus_wr(1'b1, 3'(src & 7), 8'(l));
    endtask

    task automatic get_lvl(int src, output int l);
        bus_wr(1'b0, 3'd0, 8'((src * 2) & 8'hF0));
        bus_rd(1'b1, 3'(src & 7), l);
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) ack = 1'b1;
        if (which == 1) rti = 1'b1;
        if (which == 2) cli = 1'b1;
        @(negedge clk);
        ack = 1'b0; rti = 1'b0; cli = 1'b0;
    endtask

    task automatic look(string tag, int e_irq, int e_vec);
        #1;
        chk({tag, " irq"}, int'(irq), e_irq);
        if (e_vec >= 0) chk({tag, " vec"}, int'(vec), e_vec);
    endtask

    task automatic t_reset();
        int d;
        look("R1 reset", 0, -1);
        bus_rd(1'b0, 3'd0, d); chk("R1 base", d, 0);
        get_lvl(0, d);  chk("R1 lvl0", d, 1);
        get_lvl(15, d); chk("R1 lvl15", d, 1);
        req = 16'hFFFF;
        look("R1 masked", 0, -1);
        req = '0;
    endtask

    task automatic t_config();
        int d;
        bus_wr(1'b0, 3'd0, 8'h13);
        bus_rd(1'b0, 3'd0, d); chk("R8 base mask", d, 8'h10);
        bus_wr(1'b1, 3'd5, 8'd3);
        get_lvl(13, d); chk("R8 window map", d, 3);
        get_lvl(5, d);  chk("R8 neighbour", d, 1);
        bus_wr(1'b0, 3'd0, 8'h20);
        bus_wr(1'b1, 3'd0, 8'd5);
        bus_rd(1'b1, 3'd0, d); chk("R8 out of range", d, 0);
        get_lvl(0, d);  chk("R8 no alias", d, 1);
        set_lvl(13, 1);
    endtask

    task automatic t_unmask();
        req[0] = 1'b1;
        look("R6 still masked", 0, -1);
        pulse(2);
        look("R6 after cli", 1, 0);
        req = '0;
    endtask

    task automatic t_tie();
        req[3] = 1'b1; req[9] = 1'b1;
        look("R3 tie", 1, 9);
        set_lvl(3, 4);
        look("R3 higher level", 1, 3);
        set_lvl(9, 4);
        look("R3 tie high", 1, 9);
        set_lvl(3, 1); set_lvl(9, 1);
        req = '0;
    endtask

    task automatic t_zero();
        set_lvl(12, 0);
        req[12] = 1'b1;
        look("R2 level0 alone", 0, -1);
        req[1] = 1'b1;
        look("R2 level0 loses", 1, 1);
        set_lvl(12, 1);
        req = '0;
    endtask

    task automatic t_nest();
        set_lvl(2, 2); set_lvl(5, 4); set_lvl(7, 6); set_lvl(4, 6); set_lvl(8, 5);
        req[2] = 1'b1;
        look("R3 single", 1, 2);
        pulse(0);
        look("R5 entry masks", 0, 2);
        pulse(2);
        look("R4 equal level", 0, -1);
        req[5] = 1'b1;
        look("R4 higher nests", 1, 5);
        pulse(0);
        pulse(2);
        look("R4 equal level 2nd", 0, 5);
        req[8] = 1'b1;
        look("R4 level5 over 4", 1, 8);
        req[8] = 1'b0;
        req[7] = 1'b1;
        look("R4 third", 1, 7);
        pulse(0);
        req[7] = 1'b0;
        look("R9 vec held", 0, 7);
        req[7] = 1'b1;
        pulse(2);
        req[4] = 1'b1; req[8] = 1'b1;
        look("R4 equal level 3rd", 0, 7);
        req[8] = 1'b0;
        pulse(1);
        look("R7 pop to 4", 1, 7);
        req[7] = 1'b0; req[4] = 1'b0;
        look("R7 level 4 holds", 0, -1);
        pulse(1);
        look("R7 pop to 2", 1, 5);
        req[5] = 1'b0;
        look("R7 level 2 holds", 0, -1);
        pulse(1);
        look("R7 pop to 0", 1, 2);
        pulse(1);
        look("R7 empty rti", 1, 2);
        req = '0;
    endtask

    task automatic t_stray_ack();
        look("R5 idle", 0, -1);
        pulse(0);
        req[0] = 1'b1;
        look("R5 stray ack ignored", 1, 0);
        req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_unmask();
        t_tie();
        t_zero();
        t_nest();
        t_stray_ack();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule